// File: doc/BRIEF.md
# Pipelined Core-to-Bank Request Crossbar

This block carries requests from eight processor cores to nine destinations: eight cache banks and one non-cacheable / I/O unit. Each core-to-destination pairing has its own two-entry request queue, so a core that is stalled on one busy destination can still send to the others. Every destination has its own round-robin arbiter. In each cycle that arbiter takes the head of one non-empty queue, and the winning request then moves through a fixed pipeline to a registered output.

Each request travels through four register stages. The first is the request stage, where the queue is written. The second is arbitration, where a winner is granted, its queue is popped and its head payload is captured. The third is selection, where the winner's source index and payload are aligned. The fourth is transmission, the output register. Each destination has its own lane, so all nine destinations can deliver in the same cycle. A given destination delivers at most one request per cycle. Each pair queue is a small state machine:
- Q_EMPTY goes to Q_ONE on a push.
- Q_ONE goes to Q_TWO on a push without a pop.
- Q_ONE goes back to Q_EMPTY on a pop without a push.
- Q_ONE stays in Q_ONE on a push and pop together.
- Q_TWO goes to Q_ONE on a pop.

A per-pair full flag goes back to the cores as backpressure. The payload is opaque.

Top module: `bank_xbar`

## Requirements
- R1: Destination codes 0 to 7 select cache banks and code 8 selects the I/O unit. A request whose 4-bit destination code is 9 or higher is ignored: no queue takes it and nothing is ever delivered for it.
- R2: A request from source s to destination d is accepted at the clock edge when req_valid[s] is high and pair_full[s*9+d] is low. The full flag reflects the queue state before that edge.
- R3: Each pair queue holds at most two requests. pair_full[s*9+d] is high exactly when two are held. A request presented while its pair is full is dropped and never delivered. A full pair stays full until its queue is popped.
- R4: Each destination delivers at most one request per cycle. out_src[d*3+:3] names the source of the delivered request.
- R5: Each destination arbiter grants, among sources whose pair queue is non-empty, the first one at or after its pointer in ascending order with wrap-around. After a grant, the pointer moves to the winner plus one. Reset sets every pointer to source 0.
- R6: A request presented in cycle t to an idle destination with an empty pair queue is delivered with out_valid[d] high in cycle t+4, and not before.
- R7: Different destinations deliver in the same cycle without interfering, so eight banks can each deliver in one cycle.
- R8: Requests from one source to one destination are delivered in the order they were accepted, with their payload unchanged.
- R9: Reset empties every pair queue and clears the pipeline: all pair_full and out_valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Per-source request strobe |
| req_dest | input | 32 | Per-source destination code, 4 bits per source |
| req_data | input | 256 | Per-source opaque payload, 32 bits per source |
| pair_full | output | 72 | Full flag per source/destination pair, bit s*9+d |
| out_valid | output | 9 | Per-destination delivery strobe |
| out_src | output | 27 | Per-destination source index, 3 bits per destination |
| out_data | output | 288 | Per-destination delivered payload, 32 bits per destination |

## Verification
The assertions check the following on every cycle:
- No queue is pushed while it holds two requests.
- No queue is popped while it is empty.
- Each arbiter grant is one-hot and goes only to a requesting source.
- A source is granted twice in a row only when it was the sole requester.
- A full pair stays full until it is popped.
- Every delivery was granted exactly three cycles earlier.

Only the bench's scenarios can show the end-to-end properties:
- The exact rotation order after reset.
- The loss of requests pushed into a full pair.
- Per-pair ordering and payload integrity.
- The handling of out-of-range destination codes.
- Simultaneous delivery across banks.

The bench compares against a cycle model of queues and pointers over directed and random traffic.

// File: rtl/bxb_pkg.sv
package bxb_pkg;
    localparam int unsigned BXB_NSRC = 8;
    localparam int unsigned BXB_NDST = 9;
    localparam int unsigned BXB_PW   = 32;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_TWO   = 2'd2
    } pq_state_e;
endpackage

// File: rtl/bxb_pair_queue.sv
module bxb_pair_queue
    import bxb_pkg::*;
#(
    parameter int unsigned PW = BXB_PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_data,
    input  logic          pop,
    output logic [PW-1:0] head,
    output logic          not_empty,
    output logic          full
);
    pq_state_e     st_q, st_d;
    logic [PW-1:0] slot0_q, slot1_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= Q_EMPTY;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_EMPTY: if (push) st_d = Q_ONE;
            Q_ONE: begin
                if (push && !pop)      st_d = Q_TWO;
                else if (!push && pop) st_d = Q_EMPTY;
            end
            Q_TWO:   if (pop) st_d = Q_ONE;
            default: st_d = Q_EMPTY;
        endcase
    end

    // storage: slot0 is always the head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
        end else if (pop) begin
            slot0_q <= (st_q == Q_TWO) ? slot1_q : push_data;
        end else if (push) begin
            if (st_q == Q_EMPTY) slot0_q <= push_data;
            else                 slot1_q <= push_data;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            Q_EMPTY: begin not_empty = 1'b0; full = 1'b0; end
            Q_ONE:   begin not_empty = 1'b1; full = 1'b0; end
            Q_TWO:   begin not_empty = 1'b1; full = 1'b1; end
            default: begin not_empty = 1'b0; full = 1'b0; end
        endcase
    end
    assign head = slot0_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q != Q_TWO));
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q != Q_EMPTY));
endmodule

// File: rtl/bxb_rr_arbiter.sv
module bxb_rr_arbiter #(
    parameter  int unsigned N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q;

    always_comb begin
        gnt       = '0;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < int'(N); i++) begin
            int            c;
            logic [IW-1:0] cidx;
            c = int'(ptr_q) + i;
            if (c >= int'(N)) c = c - int'(N);
            cidx = IW'(c);
            if (!gnt_valid && req[cidx]) begin
                gnt_valid  = 1'b1;
                gnt_idx    = cidx;
                gnt[cidx]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (gnt_valid)
            ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
    end

    assert_onehot_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    assert_rr_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && $past(gnt_valid) && (gnt_idx == $past(gnt_idx)))
            |-> ($countones($past(req)) == 1));
endmodule

// File: rtl/bxb_dest_lane.sv
module bxb_dest_lane #(
    parameter  int unsigned NSRC = 8,
    parameter  int unsigned PW   = 32,
    localparam int unsigned SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC*PW-1:0] heads,
    input  logic [NSRC-1:0]    avail,
    output logic [NSRC-1:0]    pop,
    output logic               out_valid,
    output logic [SW-1:0]      out_src,
    output logic [PW-1:0]      out_data
);
    logic          gnt_valid;
    logic [SW-1:0] gnt_idx;

    bxb_rr_arbiter #(.N(NSRC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (avail),
        .gnt       (pop),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    // arbitration stage, selection stage, transmission stage
    logic          arb_v_q, sel_v_q;
    logic [SW-1:0] arb_s_q, sel_s_q;
    logic [PW-1:0] arb_d_q, sel_d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_v_q   <= 1'b0;  arb_s_q <= '0;  arb_d_q  <= '0;
            sel_v_q   <= 1'b0;  sel_s_q <= '0;  sel_d_q  <= '0;
            out_valid <= 1'b0;  out_src <= '0;  out_data <= '0;
        end else begin
            arb_v_q   <= gnt_valid;
            arb_s_q   <= gnt_idx;
            arb_d_q   <= heads[gnt_idx*PW +: PW];
            sel_v_q   <= arb_v_q;
            sel_s_q   <= arb_s_q;
            sel_d_q   <= arb_d_q;
            out_valid <= sel_v_q;
            out_src   <= sel_s_q;
            out_data  <= sel_d_q;
        end
    end

    assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(gnt_valid, 3));
endmodule

// File: rtl/bank_xbar.sv
module bank_xbar
    import bxb_pkg::*;
#(
    parameter  int unsigned NSRC = BXB_NSRC,
    parameter  int unsigned NDST = BXB_NDST,
    parameter  int unsigned PW   = BXB_PW,
    localparam int unsigned DW   = $clog2(NDST),
    localparam int unsigned SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      req_valid,
    input  logic [NSRC*DW-1:0]   req_dest,
    input  logic [NSRC*PW-1:0]   req_data,
    output logic [NSRC*NDST-1:0] pair_full,
    output logic [NDST-1:0]      out_valid,
    output logic [NDST*SW-1:0]   out_src,
    output logic [NDST*PW-1:0]   out_data
);
    logic [NSRC-1:0]    lane_avail [NDST];
    logic [NSRC-1:0]    lane_pop   [NDST];
    logic [NSRC*PW-1:0] lane_heads [NDST];

    for (genvar s = 0; s < int'(NSRC); s++) begin : g_src
        for (genvar d = 0; d < int'(NDST); d++) begin : g_dst
            logic          push_w, ne_w, full_w;
            logic [PW-1:0] head_w;

            assign push_w = req_valid[s] && (req_dest[s*DW +: DW] == DW'(d)) && !full_w;
            assign pair_full[s*NDST + d]      = full_w;
            assign lane_avail[d][s]           = ne_w;
            assign lane_heads[d][s*PW +: PW]  = head_w;

            bxb_pair_queue #(.PW(PW)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push_w),
                .push_data (req_data[s*PW +: PW]),
                .pop       (lane_pop[d][s]),
                .head      (head_w),
                .not_empty (ne_w),
                .full      (full_w)
            );

            assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (full_w && !lane_pop[d][s]) |=> full_w);
        end
    end

    for (genvar d = 0; d < int'(NDST); d++) begin : g_lane
        bxb_dest_lane #(.NSRC(NSRC), .PW(PW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .heads     (lane_heads[d]),
            .avail     (lane_avail[d]),
            .pop       (lane_pop[d]),
            .out_valid (out_valid[d]),
            .out_src   (out_src[d*SW +: SW]),
            .out_data  (out_data[d*PW +: PW])
        );
    end
endmodule

// File: tb/bank_xbar_test.sv
module bank_xbar_test;
    localparam int NS = 8, ND = 9, PW = 32, DW = 4, SW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     req_valid = '0;
    logic [NS*DW-1:0]  req_dest = '0;
    logic [NS*PW-1:0]  req_data = '0;
    logic [NS*ND-1:0]  pair_full;
    logic [ND-1:0]     out_valid;
    logic [ND*SW-1:0]  out_src;
    logic [ND*PW-1:0]  out_data;

    always #2 clk = ~clk;

    bank_xbar uut (.*);

    int checks = 0, fails = 0, seq = 0, dst0_seen = 0;

    // cycle model built from the requirements
    int            mcnt [NS][ND];
    logic [PW-1:0] mq   [NS][ND][2];
    int            mptr [ND];
    bit            a_v[ND], s_v[ND], o_v[ND];
    int            a_s[ND], s_s[ND], o_s[ND];
    logic [PW-1:0] a_d[ND], s_d[ND], o_d[ND];

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) for (int d = 0; d < ND; d++) mcnt[s][d] = 0;
        for (int d = 0; d < ND; d++) begin
            mptr[d] = 0; a_v[d] = 0; s_v[d] = 0; o_v[d] = 0;
        end
    endtask

    function automatic logic [PW-1:0] mk(input int s, input int d);
        seq++;
        return PW'((seq << 8) | (s << 4) | d);
    endfunction

    // one clock: drive at negedge, model the edge, sample at next negedge
    task automatic step(input logic [NS-1:0] v, input logic [NS*DW-1:0] dst, input logic [NS*PW-1:0] dat);
        logic [NS*ND-1:0] ef;
        logic [ND-1:0]    ev;
        bit               acc[NS];
        int               ad[NS];
        req_valid = v; req_dest = dst; req_data = dat;
        #1;
        for (int s = 0; s < NS; s++) for (int d = 0; d < ND; d++) ef[s*ND+d] = (mcnt[s][d] == 2);
        check(pair_full == ef, "R2 pair_full", 128'(pair_full), 128'(ef));
        for (int s = 0; s < NS; s++) begin
            ad[s]  = int'(dst[s*DW +: DW]);
            acc[s] = v[s] && (ad[s] < ND) && (ad[s] >= 0 ? mcnt[s][ad[s] % ND] < 2 : 0);
        end
        for (int d = 0; d < ND; d++) begin
            o_v[d] = s_v[d]; o_s[d] = s_s[d]; o_d[d] = s_d[d];
            s_v[d] = a_v[d]; s_s[d] = a_s[d]; s_d[d] = a_d[d];
            a_v[d] = 0;
            for (int i = 0; i < NS; i++) begin
                int c;
                c = (mptr[d] + i) % NS;
                if (!a_v[d] && mcnt[c][d] > 0) begin
                    a_v[d] = 1; a_s[d] = c; a_d[d] = mq[c][d][0];
                    mq[c][d][0] = mq[c][d][1];
                    mcnt[c][d]--;
                    mptr[d] = (c + 1) % NS;
                end
            end
        end
        for (int s = 0; s < NS; s++) if (acc[s]) begin
            mq[s][ad[s]][mcnt[s][ad[s]]] = dat[s*PW +: PW];
            mcnt[s][ad[s]]++;
        end
        @(posedge clk); @(negedge clk);
        for (int d = 0; d < ND; d++) ev[d] = o_v[d];
        check(out_valid == ev, "R4 out_valid", 128'(out_valid), 128'(ev));
        if (out_valid[0]) dst0_seen++;
        for (int d = 0; d < ND; d++) if (o_v[d] && out_valid[d]) begin
            check(out_src[d*SW +: SW] == SW'(o_s[d]), "R8 order src", 128'(out_src[d*SW +: SW]), 128'(o_s[d]));
            check(out_data[d*PW +: PW] == o_d[d], "R8 order data", 128'(out_data[d*PW +: PW]), 128'(o_d[d]));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = '0;
        model_reset();
        repeat (3) @(negedge clk);
        check(pair_full == '0, "R9 reset pair_full", 128'(pair_full), 128'(0));
        check(out_valid == '0, "R9 reset out_valid", 128'(out_valid), 128'(0));
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NS-1:0]    v;
        logic [NS*DW-1:0] dst;
        logic [NS*PW-1:0] dat;
        void'($urandom(32'h1badc0de));
        @(negedge clk);
        do_reset();

        // R5: all sources to destination 2 right after reset -> served 0..7
        for (int s = 0; s < NS; s++) begin dst[s*DW +: DW] = 4'd2; dat[s*PW +: PW] = mk(s, 2); end
        step('1, dst, dat);
        idle(2);
        for (int k = 0; k < NS; k++) begin
            idle(1);
            check(out_valid[2] && out_src[2*SW +: SW] == SW'(k), "R5 rotation order",
                  128'(out_src[2*SW +: SW]), 128'(k));
        end

        // R6: single request, delivery exactly four cycles after presentation
        dst = '0; dat = '0;
        dst[3*DW +: DW] = 4'd5; dat[3*PW +: PW] = mk(3, 5);
        step(8'h08, dst, dat);
        idle(2);
        check(out_valid[5] == 1'b0, "R6 not early", 128'(out_valid[5]), 128'(0));
        idle(1);
        check(out_valid[5] && out_src[5*SW +: SW] == 3'd3, "R6 on time", 128'(out_valid[5]), 128'(1));
        idle(2);

        // R3: saturate destination 0, excess pushes dropped
        dst0_seen = 0;
        for (int r = 0; r < 3; r++) begin
            for (int s = 0; s < NS; s++) begin dst[s*DW +: DW] = 4'd0; dat[s*PW +: PW] = mk(s, 0); end
            step('1, dst, dat);
            if (r == 1) begin
                check(pair_full[1*ND+0] == 1'b1, "R3 full at two", 128'(pair_full[ND]), 128'(1));
                check(pair_full[0] == 1'b0, "R3 popped pair not full", 128'(pair_full[0]), 128'(0));
            end
        end
        idle(24);
        check(dst0_seen == 17, "R3 dropped when full", 128'(dst0_seen), 128'(17));

        // R1: out-of-range codes ignored
        for (int s = 0; s < NS; s++) begin dst[s*DW +: DW] = DW'(9 + s % 7); dat[s*PW +: PW] = mk(s, 9); end
        step('1, dst, dat);
        idle(5);
        check(out_valid == '0 && pair_full == '0, "R1 invalid code ignored",
              128'(out_valid), 128'(0));
        // R1: code 8 reaches the I/O lane
        dst = '0; dst[7*DW +: DW] = 4'd8; dat[7*PW +: PW] = mk(7, 8);
        step(8'h80, dst, dat);
        idle(3);
        check(out_valid[8] && out_src[8*SW +: SW] == 3'd7, "R1 io destination",
              128'(out_valid[8]), 128'(1));

        // R7: every bank delivers in the same cycle
        for (int s = 0; s < NS; s++) begin dst[s*DW +: DW] = DW'(s); dat[s*PW +: PW] = mk(s, s); end
        step('1, dst, dat);
        idle(3);
        check(out_valid[7:0] == 8'hFF, "R7 concurrent banks", 128'(out_valid), 128'(8'hFF));
        idle(2);

        // R9: reset in the middle of traffic
        for (int s = 0; s < NS; s++) begin dst[s*DW +: DW] = DW'(s % 3); dat[s*PW +: PW] = mk(s, s % 3); end
        step('1, dst, dat);
        step('1, dst, dat);
        @(negedge clk);
        do_reset();
        idle(4);

        // random traffic, with hot-spot phases
        for (int blk = 0; blk < 12; blk++) begin
            int hot;
            hot = (blk % 3 == 2) ? int'($urandom_range(0, ND - 1)) : -1;
            for (int i = 0; i < 120; i++) begin
                v = NS'($urandom);
                for (int s = 0; s < NS; s++) begin
                    int dd;
                    if (hot >= 0)                         dd = hot;
                    else if ($urandom_range(0, 15) == 0) dd = int'($urandom_range(9, 15));
                    else                                  dd = int'($urandom_range(0, ND - 1));
                    dst[s*DW +: DW] = DW'(dd);
                    dat[s*PW +: PW] = mk(s, dd);
                end
                step(v, dst, dat);
            end
        end
        idle(30);
        check(out_valid == '0 && pair_full == '0, "R8 drained", 128'(pair_full), 128'(0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule